// File: doc/BRIEF.md
# Device-to-Memory DMA Transfer Controller

This block is a single-channel DMA engine that copies a block of bytes from one I/O device into system memory while the CPU is off the bus. Software loads a start address, a byte count and an enable bit through a small register port while the engine is idle. When the device raises its request line, the engine asks the CPU for the shared bus and waits for the CPU to hand it over.

Once it owns the bus, the engine moves one byte every four clocks. It puts the device address on the address bus and pulses a read strobe, and it latches the byte the device places on the data bus. It then puts the current memory address on the bus together with the latched byte and pulses a write strobe. After each byte the memory address steps up and the remaining count steps down.

The engine hands the bus back when the count is used up, and then it raises a done flag. It also hands the bus back, without setting the flag, when the device withdraws its request. In that case it resumes where it stopped when the request returns. Every bus output is forced inactive while the grant is low, which stands in for releasing a tri-state bus.

Top module: `byte_dma`

## Requirements
- R1: During and straight after reset, busReq, busOe, busRd, busWr and doneIrq are all low.
- R2: When the engine is idle, armed, holds a non-zero count and sees devReq high, it raises busReq. busOe, busRd and busWr stay low until busAck is high.
- R3: Each byte takes four clocks. The first clock puts DEV_ADDR on busAddr. The second keeps it there with busRd high and captures busDataIn. The third puts the memory address on busAddr with the byte on busDataOut. The fourth keeps both there with busWr high. Each strobe lasts one clock, and its address is already on the bus the clock before.
- R4: The first byte goes to the start address. Each following byte goes to the next address, with carry across the full ADDR_W width. Exactly `count` bytes are written.
- R5: After the write strobe of the last byte, busReq drops on the next clock and doneIrq rises. The enable clears, and doneIrq stays high until the next write of 1 to the enable bit.
- R6: If devReq is low when a write strobe ends, busReq drops on the next clock and doneIrq stays low. The remaining count and address are kept, and the transfer continues when devReq rises again.
- R7: busOe is high only while busReq and busAck are both high. Whenever busOe is low, busAddr, busRd and busWr are zero.
- R8: Register select 0 loads the start address, select 1 loads the count, and select 2 bit 0 sets the enable (1 arms the engine and clears doneIrq, 0 disarms it). Writes are ignored unless the engine is idle.
- R9: Arming with a count of zero never raises busReq.
- R10: After it drops busReq, the engine raises it again only after busAck has been seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgSel | input | 2 | Register select (0 address, 1 count, 2 control) |
| cfgWrData | input | ADDR_W | Register write data |
| devReq | input | 1 | Transfer request from the I/O device |
| busReq | output | 1 | Bus request to the CPU |
| busAck | input | 1 | Bus grant from the CPU |
| busOe | output | 1 | Engine drives the bus |
| busAddr | output | ADDR_W | Address bus |
| busRd | output | 1 | Read strobe to the device |
| busWr | output | 1 | Write strobe to memory |
| busDataIn | input | DATA_W | Data bus as driven by the device |
| busDataOut | output | DATA_W | Data bus as driven by the engine |
| doneIrq | output | 1 | Block complete flag |

## Verification
The bench grants the bus two clocks late. An engine that drove the bus before the grant, or kept driving it after the request fell, would show active outputs with busAck low. A transfer that starts at 0x00FF checks the address carry; a narrow incrementer would land the second byte at 0x0000 instead of 0x0100. Dropping devReq during the first write strobe must leave exactly one byte written and no done flag. The transfer must then resume at the next address; a design that forgot its place would rewrite the start address or lose the count. Register writes made while the bus is held, and an arm with a zero count, must change nothing on the bus or in memory.

// File: rtl/byte_dma_pkg.sv
package byte_dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_DEVADDR,
    ST_DEVRD,
    ST_MEMADDR,
    ST_MEMWR,
    ST_RELEASE
  } dmaState_e;

  typedef struct packed {
    logic driveEn;
    logic selMem;
    logic rdStb;
    logic wrStb;
    logic capture;
    logic advance;
  } dmaStrobes_t;

  localparam logic [1:0] CFG_ADDR  = 2'd0;
  localparam logic [1:0] CFG_COUNT = 2'd1;
  localparam logic [1:0] CFG_CTRL  = 2'd2;

endpackage

// File: rtl/byte_dma_ctrl.sv
module byte_dma_ctrl
  import byte_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        devReq,
  input  logic        busAck,
  input  logic        canStart,
  input  logic        lastByte,
  output logic        busReq,
  output logic        idle,
  output dmaStrobes_t stb
);

  dmaState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (canStart && devReq && !busAck) stateNext = ST_REQ;
      ST_REQ:     if (busAck) stateNext = ST_DEVADDR;
      ST_DEVADDR: stateNext = ST_DEVRD;
      ST_DEVRD:   stateNext = ST_MEMADDR;
      ST_MEMADDR: stateNext = ST_MEMWR;
      ST_MEMWR:   stateNext = (lastByte || !devReq) ? ST_RELEASE : ST_DEVADDR;
      ST_RELEASE: if (!busAck) stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  logic inXfer;
  assign inXfer = (state == ST_DEVADDR) || (state == ST_DEVRD) ||
                  (state == ST_MEMADDR) || (state == ST_MEMWR);

  assign busReq = (state == ST_REQ) || inXfer;
  assign idle   = (state == ST_IDLE);

  always_comb begin
    stb         = '0;
    stb.driveEn = inXfer && busAck;
    stb.selMem  = (state == ST_MEMADDR) || (state == ST_MEMWR);
    stb.rdStb   = (state == ST_DEVRD);
    stb.wrStb   = (state == ST_MEMWR);
    stb.capture = (state == ST_DEVRD);
    stb.advance = (state == ST_MEMWR);
  end

endmodule

// File: rtl/byte_dma_datapath.sv
module byte_dma_datapath
  import byte_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 16'hF000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic              idle,
  input  dmaStrobes_t       stb,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              canStart,
  output logic              lastByte,
  output logic              busOe,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRd,
  output logic              busWr,
  output logic [DATA_W-1:0] busDataOut,
  output logic              doneIrq
);

  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] memAddr;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] dataReg;
  logic              armed;
  logic              done;
  logic              cfgTake;

  assign cfgTake = cfgWrEn && idle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
      count   <= '0;
      dataReg <= '0;
      armed   <= 1'b0;
      done    <= 1'b0;
    end else begin
      if (cfgTake) begin
        unique case (cfgSel)
          CFG_ADDR:  memAddr <= cfgWrData;
          CFG_COUNT: count   <= cfgWrData[CNT_W-1:0];
          CFG_CTRL: begin
            armed <= cfgWrData[0];
            if (cfgWrData[0]) done <= 1'b0;
          end
          default: ;
        endcase
      end
      if (stb.capture) dataReg <= busDataIn;
      if (stb.advance) begin
        memAddr <= memAddr + ADDR_ONE;
        count   <= count - CNT_ONE;
        if (count == CNT_ONE) begin
          done  <= 1'b1;
          armed <= 1'b0;
        end
      end
    end
  end

  assign canStart   = armed && (count != '0);
  assign lastByte   = (count == CNT_ONE);
  assign busOe      = stb.driveEn;
  assign busAddr    = stb.driveEn ? (stb.selMem ? memAddr : DEV_ADDR) : '0;
  assign busRd      = stb.driveEn && stb.rdStb;
  assign busWr      = stb.driveEn && stb.wrStb;
  assign busDataOut = (stb.driveEn && stb.selMem) ? dataReg : '0;
  assign doneIrq    = done;

endmodule

// File: rtl/byte_dma.sv
module byte_dma
  import byte_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 16'hF000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic              devReq,
  output logic              busReq,
  input  logic              busAck,
  output logic              busOe,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRd,
  output logic              busWr,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [DATA_W-1:0] busDataOut,
  output logic              doneIrq
);

  dmaStrobes_t stb;
  logic        idle;
  logic        canStart;
  logic        lastByte;

  byte_dma_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .devReq   (devReq),
    .busAck   (busAck),
    .canStart (canStart),
    .lastByte (lastByte),
    .busReq   (busReq),
    .idle     (idle),
    .stb      (stb)
  );

  byte_dma_datapath #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .DATA_W   (DATA_W),
    .DEV_ADDR (DEV_ADDR)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgSel     (cfgSel),
    .cfgWrData  (cfgWrData),
    .idle       (idle),
    .stb        (stb),
    .busDataIn  (busDataIn),
    .canStart   (canStart),
    .lastByte   (lastByte),
    .busOe      (busOe),
    .busAddr    (busAddr),
    .busRd      (busRd),
    .busWr      (busWr),
    .busDataOut (busDataOut),
    .doneIrq    (doneIrq)
  );

endmodule

// File: rtl/byte_dma_checker.sv
module byte_dma_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              devReq,
  input logic              busReq,
  input logic              busAck,
  input logic              busOe,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic              doneIrq
);

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R1: assert (!busReq && !busOe && !busRd && !busWr && !doneIrq);
    end
  end

  assert_grant_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOe) |-> busAck && $past(busReq));

  assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    busRd |-> $stable(busAddr) && $past(busOe) && !$past(busRd));

  assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    busWr |-> $stable(busAddr) && $past(busOe) && !$past(busWr));

  assert_done_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneIrq) |-> !busReq && $past(busWr));

  assert_req_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !devReq) |=> !busReq);

  assert_master_R7: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> busReq && busAck);

  assert_rerequest_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> !busAck);

endmodule

bind byte_dma byte_dma_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .devReq  (devReq),
  .busReq  (busReq),
  .busAck  (busAck),
  .busOe   (busOe),
  .busAddr (busAddr),
  .busRd   (busRd),
  .busWr   (busWr),
  .doneIrq (doneIrq)
);

// File: tb/sim_byte_dma.sv
module sim_byte_dma;

  localparam int ADDR_W = 16;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] DEV = 16'hF000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgSel = 2'd0;
  logic [ADDR_W-1:0] cfgWrData = '0;
  logic devReq = 1'b0;
  logic busReq, busOe, busRd, busWr, doneIrq;
  logic busAck;
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busDataIn, busDataOut;

  always #10 clk = ~clk;

  byte_dma #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .DEV_ADDR(DEV)) u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .devReq(devReq), .busReq(busReq), .busAck(busAck), .busOe(busOe), .busAddr(busAddr),
    .busRd(busRd), .busWr(busWr), .busDataIn(busDataIn), .busDataOut(busDataOut),
    .doneIrq(doneIrq)
  );

  // CPU model: grants and releases two clocks after the request changes
  logic ackPipe;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin ackPipe <= 1'b0; busAck <= 1'b0; end
    else begin ackPipe <= busReq; busAck <= ackPipe; end
  end

  // device and memory models
  function automatic logic [7:0] devByte(input int i);
    return 8'(i * 7 + 3);
  endfunction

  int devIdx = 0;
  int wrCount = 0;
  logic [ADDR_W-1:0] lastWrAddr = '0;
  logic [7:0] mem [256];
  logic memClr = 1'b0;

  assign busDataIn = (busRd && busAddr == DEV) ? devByte(devIdx) : 8'h00;

  always @(posedge clk) begin
    if (memClr) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
      wrCount <= 0;
    end else if (busWr) begin
      mem[busAddr[7:0]] <= busDataOut;
      lastWrAddr <= busAddr;
      wrCount <= wrCount + 1;
    end
    if (busRd) devIdx <= devIdx + 1;
  end

  int checks = 0;
  int errors = 0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus-rule monitor
  logic [ADDR_W-1:0] prevAddr = '0;
  logic prevOe = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if ((busOe || busRd || busWr) && !busAck)
        check(1'b0, "R7 bus driven without grant", int'(busOe), 0);
      if (!busOe && (busAddr != '0 || busRd || busWr))
        check(1'b0, "R7 outputs active while released", int'(busAddr), 0);
      if ((busRd || busWr) && (!prevOe || busAddr != prevAddr))
        check(1'b0, "R3 strobe address not set up", int'(busAddr), int'(prevAddr));
      if (busRd && busAddr != DEV)
        check(1'b0, "R3 read not at device", int'(busAddr), int'(DEV));
    end
    prevAddr = busAddr;
    prevOe = busOe;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic cfgWrite(input logic [1:0] sel, input logic [ADDR_W-1:0] val);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = val;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic clearMem();
    @(negedge clk); memClr = 1'b1;
    @(negedge clk); memClr = 1'b0;
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (!doneIrq && n < 2000) begin @(negedge clk); n++; end
    check(doneIrq, tag, int'(doneIrq), 1);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check(!busReq && !busOe && !busRd && !busWr && !doneIrq, "R1 reset outputs",
          int'({busReq, busOe, busRd, busWr, doneIrq}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busReq && !doneIrq, "R1 after reset", int'({busReq, doneIrq}), 0);
  endtask

  task automatic testBasic(input logic [ADDR_W-1:0] start, input int n, input string tag);
    int base;
    clearMem();
    base = devIdx;
    cfgWrite(2'd0, start);
    cfgWrite(2'd1, ADDR_W'(n));
    cfgWrite(2'd2, 16'd1);
    check(!doneIrq, "R5 arm clears done", int'(doneIrq), 0);
    devReq = 1'b1;
    @(negedge clk);
    check(busReq && !busOe, "R2 request before grant", int'({busReq, busOe}), 2);
    waitDone({tag, " R5 done"});
    check(!busReq, "R5 request dropped with done", int'(busReq), 0);
    check(wrCount == n, {tag, " R4 byte count"}, wrCount, n);
    for (int i = 0; i < n; i++)
      check(mem[8'(start + ADDR_W'(i))] == devByte(base + i), {tag, " R3 data"},
            int'(mem[8'(start + ADDR_W'(i))]), int'(devByte(base + i)));
    check(lastWrAddr == start + ADDR_W'(n - 1), {tag, " R4 last address"},
          int'(lastWrAddr), int'(start + ADDR_W'(n - 1)));
    devReq = 1'b0;
    settle();
    check(doneIrq && !busReq, "R5 done holds", int'({doneIrq, busReq}), 2);
  endtask

  task automatic testDrop();
    int base;
    int guard = 0;
    clearMem();
    base = devIdx;
    cfgWrite(2'd0, 16'h0080);
    cfgWrite(2'd1, 16'd5);
    cfgWrite(2'd2, 16'd1);
    devReq = 1'b1;
    while (!busWr && guard < 200) begin @(negedge clk); guard++; end
    devReq = 1'b0;
    @(negedge clk);
    check(!busReq, "R6 release after current byte", int'(busReq), 0);
    settle();
    check(wrCount == 1, "R6 one byte written", wrCount, 1);
    check(!doneIrq, "R6 no done on drop", int'(doneIrq), 0);
    devReq = 1'b1;
    waitDone("R6 resume done");
    check(wrCount == 5, "R6 total bytes", wrCount, 5);
    for (int i = 0; i < 5; i++)
      check(mem[8'h80 + 8'(i)] == devByte(base + i), "R6 resumed data",
            int'(mem[8'h80 + 8'(i)]), int'(devByte(base + i)));
    devReq = 1'b0;
    settle();
  endtask

  task automatic testCfgIgnored();
    int guard = 0;
    clearMem();
    cfgWrite(2'd0, 16'h0020);
    cfgWrite(2'd1, 16'd3);
    cfgWrite(2'd2, 16'd1);
    devReq = 1'b1;
    while (!busReq && guard < 50) begin @(negedge clk); guard++; end
    cfgWrite(2'd0, 16'h0010);
    cfgWrite(2'd1, 16'd9);
    waitDone("R8 done");
    check(wrCount == 3, "R8 count write ignored when busy", wrCount, 3);
    check(mem[8'h10] == 8'h00, "R8 address write ignored when busy", int'(mem[8'h10]), 0);
    check(lastWrAddr == 16'h0022, "R8 original address kept", int'(lastWrAddr), 16'h22);
    devReq = 1'b0;
    settle();
  endtask

  task automatic testDisarmAndZero();
    clearMem();
    cfgWrite(2'd0, 16'h0040);
    cfgWrite(2'd1, 16'd2);
    cfgWrite(2'd2, 16'd1);
    cfgWrite(2'd2, 16'd0);
    devReq = 1'b1;
    repeat (20) @(negedge clk);
    check(!busReq && wrCount == 0, "R8 disarm blocks request", int'(busReq), 0);
    devReq = 1'b0;
    cfgWrite(2'd1, 16'd0);
    cfgWrite(2'd2, 16'd1);
    devReq = 1'b1;
    repeat (20) @(negedge clk);
    check(!busReq && wrCount == 0, "R9 zero count no request", int'(busReq), 0);
    check(!doneIrq, "R9 no done for zero count", int'(doneIrq), 0);
    devReq = 1'b0;
  endtask

  task automatic testBackToBack();
    int base;
    int guard = 0;
    clearMem();
    base = devIdx;
    cfgWrite(2'd0, 16'h0060);
    cfgWrite(2'd1, 16'd3);
    cfgWrite(2'd2, 16'd1);
    devReq = 1'b1;
    while (!busWr && guard < 200) begin @(negedge clk); guard++; end
    devReq = 1'b0;
    @(negedge clk);
    devReq = 1'b1;
    @(negedge clk);
    check(!busReq, "R10 no request while grant still high", int'(busReq), 0);
    waitDone("R10 resume done");
    check(mem[8'h62] == devByte(base + 2), "R10 final byte", int'(mem[8'h62]),
          int'(devByte(base + 2)));
    devReq = 1'b0;
    settle();
  endtask

  initial begin
    testReset();
    testBasic(16'h0040, 4, "basic");
    testBasic(16'h00FF, 2, "carry");
    testBasic(16'h0003, 1, "single");
    testDrop();
    testCfgIgnored();
    testDisarmAndZero();
    testBackToBack();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule